// File: doc/BRIEF.md
# Two-Way Write-Back Byte Cache

This block is a small data cache between a processor that issues single-byte loads and stores and a memory that moves whole 16-byte blocks. It holds 256 bytes as 8 sets of 2 ways. Each way stores one block with its own valid bit, dirty bit and tag. Each set also keeps a pointer to its most recently used way.

A request is presented with `cpu_req_valid` and the address, store flag and store byte. These inputs stay stable until `cpu_req_ready` is seen high. A hit is accepted in the cycle it is presented, and the response byte appears one cycle later.

On a miss the request is stalled. If the chosen victim is dirty, its block is first written to memory. The missing block is then fetched into that way. The request is then looked up again and hits. A store that misses therefore allocates the block and merges its byte into it.

Top module: `sa2_wb_cache`

## Requirements
- R1: The address is split into a tag in bits 15:7, a set index in bits 6:4 and a byte offset in bits 3:0. Every memory-side address is block-aligned, formed as {tag, set, 4'b0000}.
- R2: Reset clears every valid and dirty bit. A tag of zero is an ordinary tag, so after reset a load of 0x0010 (tag 0, set 1) misses and causes one block read at 0x0010.
- R3: A miss reads the whole 16-byte block that contains the address into one way. The requested byte is then returned from that block, where byte k of the block is `mem_rdata[8k+7:8k]`.
- R4: Two different blocks that map to the same set (0xab00 and 0xcd00, both in set 0) are placed in different ways. After both are loaded, each of them hits.
- R5: A store hit writes only the cached byte and marks the line dirty. It causes no memory request.
- R6: When the victim line is dirty, its 16 bytes are written to memory at the victim's block address before the read of the new block is issued.
- R7: A clean victim is dropped with no write to memory.
- R8: An invalid way in the set is filled before any valid way is replaced. When both ways are valid, the way that is not the set's most recently used way (the last way to be accepted as a hit) is replaced.
- R9: A store miss allocates: the block is fetched, the store byte is merged into it, and the line becomes dirty. A later eviction of that line writes the stored byte back to memory.
- R10: `cpu_req_ready` rises in the same cycle as a valid request that hits. `cpu_rvalid` pulses in the cycle after acceptance. During a miss, `cpu_req_ready` stays low until the refill has been written. The response byte is the loaded byte for a load and the stored byte for a store.
- R11: A repeated access to a resident block (0xface and then 0xfac0) hits with no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle (hit) |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rvalid | output | 1 | Response valid, one cycle after acceptance |
| cpu_rdata | output | 8 | Loaded byte, or the stored byte for a store |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 16 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written back |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | 128 | Block returned with a read acknowledge |

## Verification
The hardest state to reach from the ports is a full set whose replacement choice depends on recent use, with a dirty line in the way that must go. The stimulus builds this in set 0. It first fills both ways. It then dirties one way with a store hit and touches lines in a chosen order to steer the most-recently-used pointer. Only then does it bring in a new block, so that the dirty way is the victim.

The write-back's address, its merged byte, and its position ahead of the refill read are checked against a log kept by the memory model. A second chain does the same for a line made dirty by a store miss.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int AW     = 16;
  localparam int OW     = 4;
  localparam int SW     = 3;
  localparam int NWAY   = 2;
  localparam int TW     = AW - SW - OW;
  localparam int NSET   = 1 << SW;
  localparam int LINE_W = 8 << OW;
  localparam int WYW    = (NWAY > 1) ? $clog2(NWAY) : 1;

  typedef logic [AW-1:0]     addr_t;
  typedef logic [TW-1:0]     tag_t;
  typedef logic [SW-1:0]     set_t;
  typedef logic [OW-1:0]     off_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [WYW-1:0]    way_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL} cst_t;

  function automatic tag_t f_tag(addr_t a);
    return a[AW-1 -: TW];
  endfunction

  function automatic set_t f_set(addr_t a);
    return a[OW +: SW];
  endfunction

  function automatic off_t f_off(addr_t a);
    return a[OW-1:0];
  endfunction

  function automatic addr_t f_blk(tag_t t, set_t s);
    return {t, s, {OW{1'b0}}};
  endfunction

  function automatic logic [7:0] f_get_byte(line_t l, off_t o);
    return l[int'(o)*8 +: 8];
  endfunction

  // first invalid way wins; otherwise the way after the MRU one
  function automatic way_t f_victim(logic [NWAY-1:0] vld, way_t mru);
    way_t v;
    v = way_t'((int'(mru) + 1) % NWAY);
    for (int w = NWAY - 1; w >= 0; w--)
      if (!vld[w]) v = way_t'(w);
    return v;
  endfunction
endpackage

// File: rtl/wbc_arrays.sv
module wbc_arrays
  import wbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  set_t                  lk_set,
  input  tag_t                  lk_tag,
  output logic [NWAY-1:0]       hit_vec,
  output logic [NWAY-1:0]       valid_vec,
  output logic [NWAY-1:0]       dirty_vec,
  output way_t                  mru_way,
  output line_t [NWAY-1:0]      line_rd,
  output tag_t  [NWAY-1:0]      tag_rd,
  input  logic                  st_en,
  input  way_t                  st_way,
  input  off_t                  st_off,
  input  logic [7:0]            st_byte,
  input  logic                  fl_en,
  input  way_t                  fl_way,
  input  tag_t                  fl_tag,
  input  line_t                 fl_line,
  input  logic                  mru_en,
  input  way_t                  mru_in
);
  way_t mru_q [NSET];

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    line_t data_q  [NSET];
    tag_t  tag_q   [NSET];
    logic  valid_q [NSET];
    logic  dirty_q [NSET];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < NSET; s++) begin
          valid_q[s] <= 1'b0;
          dirty_q[s] <= 1'b0;
        end
      end else if (fl_en && fl_way == way_t'(w)) begin
        valid_q[lk_set] <= 1'b1;
        dirty_q[lk_set] <= 1'b0;
      end else if (st_en && st_way == way_t'(w)) begin
        dirty_q[lk_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fl_en && fl_way == way_t'(w)) begin
        data_q[lk_set] <= fl_line;
        tag_q[lk_set]  <= fl_tag;
      end else if (st_en && st_way == way_t'(w)) begin
        data_q[lk_set][int'(st_off)*8 +: 8] <= st_byte;
      end
    end

    assign valid_vec[w] = valid_q[lk_set];
    assign dirty_vec[w] = dirty_q[lk_set];
    assign line_rd[w]   = data_q[lk_set];
    assign tag_rd[w]    = tag_q[lk_set];
    assign hit_vec[w]   = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++) mru_q[s] <= '0;
    end else if (mru_en) begin
      mru_q[lk_set] <= mru_in;
    end
  end
  assign mru_way = mru_q[lk_set];

  // R4: one block never sits in two ways of a set
  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8: refill never lands on the MRU way of a full set
  a_r8_victim_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && (&valid_vec)) |-> (fl_way != mru_way));

  // R5: a store only touches a way that hits
  a_r5_store_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> hit_vec[st_way]);
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  addr_t            req_addr,
  input  logic [7:0]       req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output set_t             lk_set,
  output tag_t             lk_tag,
  input  logic [NWAY-1:0]  hit_vec,
  input  logic [NWAY-1:0]  valid_vec,
  input  logic [NWAY-1:0]  dirty_vec,
  input  way_t             mru_way,
  input  line_t [NWAY-1:0] line_rd,
  input  tag_t  [NWAY-1:0] tag_rd,
  output logic             st_en,
  output way_t             hit_way,
  output logic             fl_en,
  output way_t             vway,
  output logic             mem_req,
  output logic             mem_we,
  output addr_t            mem_addr,
  output line_t            mem_wdata,
  input  logic             mem_ack
);
  cst_t  st_q;
  way_t  vway_q;
  tag_t  vtag_q;
  tag_t  mtag_q;
  set_t  mset_q;
  logic  accept;
  logic  miss_start;
  way_t  vsel;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NWAY; w++)
      if (hit_vec[w]) hit_way = way_t'(w);
  end

  assign lk_set     = (st_q == ST_IDLE) ? f_set(req_addr) : mset_q;
  assign lk_tag     = f_tag(req_addr);
  assign req_ready  = (st_q == ST_IDLE) && (|hit_vec);
  assign accept     = req_valid && req_ready;
  assign miss_start = (st_q == ST_IDLE) && req_valid && !(|hit_vec);
  assign vsel       = f_victim(valid_vec, mru_way);
  assign st_en      = accept && req_we;
  assign fl_en      = (st_q == ST_FILL) && mem_ack;
  assign vway       = vway_q;

  assign mem_req   = (st_q == ST_WBACK) || (st_q == ST_FILL);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_addr  = (st_q == ST_WBACK) ? f_blk(vtag_q, mset_q) : f_blk(mtag_q, mset_q);
  assign mem_wdata = line_rd[vway_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vway_q <= '0;
      vtag_q <= '0;
      mtag_q <= '0;
      mset_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (miss_start) begin
          vway_q <= vsel;
          vtag_q <= tag_rd[vsel];
          mtag_q <= f_tag(req_addr);
          mset_q <= f_set(req_addr);
          st_q   <= (valid_vec[vsel] && dirty_vec[vsel]) ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_ack) st_q <= ST_FILL;
        ST_FILL:  if (mem_ack) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept)
        rsp_data <= req_we ? req_wdata : f_get_byte(line_rd[hit_way], f_off(req_addr));
    end
  end

  // R10: no acceptance while a miss is in progress
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R10: response one cycle after acceptance, never otherwise
  a_r10_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R5: a store hit is followed by no memory traffic
  a_r5_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> !mem_req);

  // R1: memory side always uses block-aligned addresses
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (f_off(mem_addr) == '0));

  // R6: a memory request holds its address until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6: after a write-back the next request is the refill read of the same set
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

// File: rtl/sa2_wb_cache.sv
module sa2_wb_cache
  import wbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_we,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic          cpu_rvalid,
  output logic [7:0]    cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [127:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [127:0]  mem_rdata
);
  set_t             lk_set;
  tag_t             lk_tag;
  logic [NWAY-1:0]  hit_vec;
  logic [NWAY-1:0]  valid_vec;
  logic [NWAY-1:0]  dirty_vec;
  way_t             mru_way;
  line_t [NWAY-1:0] line_rd;
  tag_t  [NWAY-1:0] tag_rd;
  logic             st_en;
  way_t             hit_way;
  logic             fl_en;
  way_t             vway;
  logic             accept_w;

  assign accept_w = cpu_req_valid && cpu_req_ready;

  wbc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_req_valid),
    .req_we    (cpu_we),
    .req_addr  (cpu_addr),
    .req_wdata (cpu_wdata),
    .req_ready (cpu_req_ready),
    .rsp_valid (cpu_rvalid),
    .rsp_data  (cpu_rdata),
    .lk_set    (lk_set),
    .lk_tag    (lk_tag),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .mru_way   (mru_way),
    .line_rd   (line_rd),
    .tag_rd    (tag_rd),
    .st_en     (st_en),
    .hit_way   (hit_way),
    .fl_en     (fl_en),
    .vway      (vway),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  wbc_arrays u_arrays (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (lk_set),
    .lk_tag    (lk_tag),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .mru_way   (mru_way),
    .line_rd   (line_rd),
    .tag_rd    (tag_rd),
    .st_en     (st_en),
    .st_way    (hit_way),
    .st_off    (f_off(cpu_addr)),
    .st_byte   (cpu_wdata),
    .fl_en     (fl_en),
    .fl_way    (vway),
    .fl_tag    (lk_tag),
    .fl_line   (mem_rdata),
    .mru_en    (accept_w),
    .mru_in    (hit_way)
  );

  // R9: a refill always leaves the request hitting in the next cycle
  a_r9_refill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> (|hit_vec));
endmodule

// File: tb/sa2_wb_cache_bench.sv
module sa2_wb_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_we = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic [7:0]   cpu_wdata = '0;
  logic         cpu_rvalid;
  logic [7:0]   cpu_rdata;
  logic         mem_req;
  logic         mem_we;
  logic [15:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0]   gold [int];
  logic [127:0] mblk [int];
  logic [7:0]   exp_q [$];
  int           n_rd = 0, n_wr = 0;
  logic [15:0]  last_rd_addr, last_wr_addr;
  logic [127:0] last_wr_data;
  bit           op_seq [$];

  always #5 clk = ~clk;

  sa2_wb_cache u_sa2_wb_cache (.*);

  function automatic logic [7:0] init_byte(int a);
    return a[7:0] ^ a[15:8] ^ 8'h5c;
  endfunction

  function automatic logic [7:0] gbyte(int a);
    if (gold.exists(a)) return gold[a];
    return init_byte(a);
  endfunction

  function automatic logic [127:0] mget(int ba);
    logic [127:0] b;
    if (mblk.exists(ba)) return mblk[ba];
    for (int k = 0; k < 16; k++) b[k*8 +: 8] = init_byte(ba + k);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        repeat (2) @(negedge clk);
        op_seq.push_back(mem_we);
        if (mem_we) begin
          n_wr++;
          last_wr_addr = mem_addr;
          last_wr_data = mem_wdata;
          mblk[int'(mem_addr)] = mem_wdata;
        end else begin
          n_rd++;
          last_rd_addr = mem_addr;
          mem_rdata = mget(int'(mem_addr));
        end
        mem_ack = 1'b1;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cpu_rvalid) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", cpu_rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cpu_rdata == e, "R3/R10 response byte", cpu_rdata, e);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input int exp_rd, input int exp_wr, input string req,
                        output int stalls);
    int rd0, wr0;
    rd0 = n_rd; wr0 = n_wr;
    op_seq.delete();
    stalls = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (we) begin
      exp_q.push_back(wd);
      gold[int'(a)] = wd;
    end else exp_q.push_back(gbyte(int'(a)));
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    check(cpu_rvalid == 1'b1, "R10 rvalid after accept", cpu_rvalid, 1);
    cpu_req_valid = 1'b0;
    check(n_rd - rd0 == exp_rd, {req, " block reads"}, n_rd - rd0, exp_rd);
    check(n_wr - wr0 == exp_wr, {req, " block writes"}, n_wr - wr0, exp_wr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(cpu_rvalid == 0 && mem_req == 0 && cpu_req_ready == 0, "R2 reset outputs",
          {cpu_rvalid, mem_req, cpu_req_ready}, 0);

    // R1 R3: miss fetches aligned block, byte returned
    access(0, 16'hface, 0, 1, 0, "R3 first load", st);
    check(last_rd_addr == 16'hfac0, "R1 aligned refill address", last_rd_addr, 16'hfac0);
    check(st > 0, "R10 miss stalls", st, 1);
    // R11 R10: same block hits immediately, no traffic
    access(0, 16'hfac0, 0, 0, 0, "R11 resident block", st);
    check(st == 0, "R10 hit ready same cycle", st, 0);

    // R2: tag zero is not empty
    access(0, 16'h0010, 0, 1, 0, "R2 tag zero miss", st);
    check(last_rd_addr == 16'h0010, "R2 tag zero read address", last_rd_addr, 16'h0010);

    // R4: two blocks share set 0
    access(0, 16'hab00, 0, 1, 0, "R4 fill ab00", st);
    access(0, 16'hcd00, 0, 1, 0, "R8 invalid way filled", st);
    access(0, 16'hab00, 0, 0, 0, "R4 ab00 resident", st);
    access(0, 16'hcd00, 0, 0, 0, "R4 cd00 resident", st);

    // R5: store hit, no memory traffic
    access(1, 16'hab05, 8'ha5, 0, 0, "R5 store hit", st);
    check(st == 0, "R5 store hit no stall", st, 0);
    access(0, 16'hab05, 0, 0, 0, "R5 read back", st);

    // R7 R8: MRU=ab, clean cd is victim
    access(0, 16'h1200, 0, 1, 0, "R7 clean victim", st);
    access(0, 16'hab00, 0, 0, 0, "R8 MRU survivor", st);
    access(0, 16'hcd00, 0, 1, 0, "R8 non-MRU replaced", st);

    // R6: dirty ab is victim now
    access(0, 16'h3400, 0, 1, 1, "R6 dirty victim", st);
    check(op_seq.size() == 2 && op_seq[0] == 1'b1, "R6 write before read",
          op_seq.size() > 0 ? op_seq[0] : 0, 1);
    check(last_wr_addr == 16'hab00, "R6 write-back address", last_wr_addr, 16'hab00);
    check(last_wr_data[5*8 +: 8] == 8'ha5, "R6 write-back byte", last_wr_data[5*8 +: 8], 8'ha5);
    access(0, 16'hab05, 0, 1, 0, "R6 reload from memory", st);

    // R9: store miss allocates and dirties
    access(1, 16'h5a27, 8'h3c, 1, 0, "R9 store miss", st);
    access(0, 16'h5a27, 0, 0, 0, "R9 merged byte", st);
    access(0, 16'h6620, 0, 1, 0, "R9 second way", st);
    access(0, 16'h7720, 0, 1, 1, "R9 dirty eviction", st);
    check(last_wr_addr == 16'h5a20, "R9 write-back address", last_wr_addr, 16'h5a20);
    check(last_wr_data[7*8 +: 8] == 8'h3c, "R9 write-back byte", last_wr_data[7*8 +: 8], 8'h3c);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule